// File: doc/BRIEF.md
# Flash Byte Program Sequencer

This block writes a contiguous range of bytes into a parallel flash device using a pulse-and-verify loop. Software or a higher-level controller supplies a first and a last address and pulses `start`. For each address the block asks a data source for the intended byte, arms the device for programming, writes the address and byte (which starts a program pulse), waits a fixed pulse time, arms a verify, waits a settle time, then reads the byte back and compares it.

A mismatch gives the same byte another pulse. A byte that has had its full allowance of pulses and still reads wrong aborts the whole run. A match moves on to the next address, with the pulse count starting again from zero. When the last byte verifies, the device is put back into read mode. Done is then signalled with a pass flag. The high-voltage supply enable stays asserted for the whole sequence and drops as done is signalled.

Top module: `flash_prog_seq`

## Requirements
- R1: After reset, and until `start`, the block issues no flash write or read, holds `vppEn` and `done` low.
- R2: Each program pulse is begun by a command write of 40h followed in the next cycle by a write to the current address carrying the source byte `srcData` for that address.
- R3: After the address/data write there are exactly `PULSE_CYC` idle cycles, then a command write of C0h arms the verify.
- R4: After the C0h write there are exactly `VERIFY_CYC` idle cycles, then a single read cycle; the data returned in the following cycle on `flashRdData` is compared with `srcData`.
- R5: A mismatching read causes another 40h/data/C0h/read round on the same address; a byte that verifies after N rounds receives exactly N pulses.
- R6: A byte may receive at most `MAX_PULSES` (default 25) pulses; if the last of them still mismatches, the run ends with `pass` = 0, `failAddr` = that address and `failCount` = `MAX_PULSES`, and no later address is pulsed.
- R7: Addresses are programmed in ascending order, from `startAddr` up to and including `endAddr`, each moved to only after its byte verifies; no address outside the range is written.
- R8: On success a command write of 00h (read mode) is issued in the cycle just before `done`, and `pass` = 1 while `done` is high; on failure no 00h write is issued.
- R9: `vppEn` is high during every flash write of a run and low in the `done` cycle.
- R10: `start` is ignored while a run is in progress.
- R11: `done` is high for exactly one cycle per run.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a run (sampled only when idle) |
| startAddr | input | AW | First address of the range |
| endAddr | input | AW | Last address of the range |
| srcAddr | output | AW | Address whose intended byte is requested |
| srcData | input | 8 | Intended byte for `srcAddr` (combinational source) |
| flashAddr | output | AW | Flash address bus |
| flashWrData | output | 8 | Flash write data / command byte |
| flashWe | output | 1 | One-cycle flash write strobe |
| flashRe | output | 1 | One-cycle flash read strobe |
| flashRdData | input | 8 | Read data, valid the cycle after `flashRe` |
| vppEn | output | 1 | Programming supply enable |
| done | output | 1 | One-cycle end-of-run pulse |
| pass | output | 1 | Result of the last run |
| failAddr | output | AW | Address that exhausted its pulses |
| failCount | output | clog2(MAX_PULSES+1) | Pulses given to the failing byte |

## Verification
The assertions take for granted that `startAddr` is not above `endAddr`, that `srcData` answers `srcAddr` in the same cycle, and that the flash returns read data one cycle after `flashRe`. The bench keeps to this with a flash model that answers every read at the following edge, a data source computed combinationally from the address, and ranges chosen in ascending order. The model lets each byte need a chosen number of pulses before it reads back correctly, which drives the retry, cap and failure paths.

// File: rtl/fps_pkg.sv
package fps_pkg;

  localparam logic [7:0] CMD_PROGRAM = 8'h40;
  localparam logic [7:0] CMD_VERIFY  = 8'hC0;
  localparam logic [7:0] CMD_READ    = 8'h00;

  typedef enum logic [1:0] {
    WR_PROG,
    WR_VERIFY,
    WR_READ,
    WR_DATA
  } wrSel_e;

  typedef struct packed {
    logic   loadStart;
    logic   incAddr;
    logic   clrCnt;
    logic   incCnt;
    logic   loadPulse;
    logic   loadVerify;
    logic   setPass;
    logic   setFail;
    wrSel_e wrSel;
  } strobes_t;

endpackage

// File: rtl/fps_dpath.sv
module fps_dpath
  import fps_pkg::*;
#(
  parameter int AW         = 8,
  parameter int CW         = 5,
  parameter int TW         = 5,
  parameter int PULSE_CYC  = 20,
  parameter int VERIFY_CYC = 12,
  parameter int MAX_PULSES = 25
) (
  input  logic          clk,
  input  logic          rstN,
  input  strobes_t      strb,
  input  logic [AW-1:0] startAddr,
  input  logic [AW-1:0] endAddr,
  input  logic [7:0]    srcData,
  input  logic [7:0]    flashRdData,
  output logic [AW-1:0] curAddr,
  output logic [7:0]    wrData,
  output logic          timerZero,
  output logic          lastAddr,
  output logic          match,
  output logic          cntMax,
  output logic          passFlag,
  output logic [AW-1:0] failAddr,
  output logic [CW-1:0] failCount
);

  localparam logic [TW-1:0] PULSE_LOAD  = TW'(PULSE_CYC - 1);
  localparam logic [TW-1:0] VERIFY_LOAD = TW'(VERIFY_CYC - 1);
  localparam logic [CW-1:0] CNT_LIMIT   = CW'(MAX_PULSES);

  logic [AW-1:0] addrQ, endQ, failAddrQ;
  logic [CW-1:0] cntQ, failCntQ;
  logic [TW-1:0] timerQ;
  logic          passQ;

  // address and per-byte pulse counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      endQ  <= '0;
      cntQ  <= '0;
    end else if (strb.loadStart) begin
      addrQ <= startAddr;
      endQ  <= endAddr;
      cntQ  <= '0;
    end else begin
      if (strb.incAddr) addrQ <= addrQ + AW'(1);
      if (strb.clrCnt)      cntQ <= '0;
      else if (strb.incCnt) cntQ <= cntQ + CW'(1);
    end
  end

  // delay timer for pulse and verify settle
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timerQ <= '0;
    else if (strb.loadPulse)  timerQ <= PULSE_LOAD;
    else if (strb.loadVerify) timerQ <= VERIFY_LOAD;
    else if (timerQ != '0)    timerQ <= timerQ - TW'(1);
  end

  // result registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      passQ     <= 1'b0;
      failAddrQ <= '0;
      failCntQ  <= '0;
    end else if (strb.setPass) begin
      passQ <= 1'b1;
    end else if (strb.setFail) begin
      passQ     <= 1'b0;
      failAddrQ <= addrQ;
      failCntQ  <= cntQ;
    end
  end

  always_comb begin
    unique case (strb.wrSel)
      WR_PROG:   wrData = CMD_PROGRAM;
      WR_VERIFY: wrData = CMD_VERIFY;
      WR_READ:   wrData = CMD_READ;
      default:   wrData = srcData;
    endcase
  end

  assign curAddr   = addrQ;
  assign timerZero = (timerQ == '0);
  assign lastAddr  = (addrQ == endQ);
  assign match     = (flashRdData == srcData);
  assign cntMax    = (cntQ == CNT_LIMIT);
  assign passFlag  = passQ;
  assign failAddr  = failAddrQ;
  assign failCount = failCntQ;

  // R6
  cnt_cap_chk: assert property (@(posedge clk) disable iff (!rstN)
    cntQ <= CNT_LIMIT);

  // R6
  fail_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setFail |=> (failCntQ == CNT_LIMIT) && !passQ);

  // R7
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.incAddr |=> addrQ == $past(addrQ) + AW'(1));

endmodule

// File: rtl/fps_ctrl.sv
module fps_ctrl
  import fps_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     start,
  input  logic     timerZero,
  input  logic     lastAddr,
  input  logic     match,
  input  logic     cntMax,
  output strobes_t strb,
  output logic     flashWe,
  output logic     flashRe,
  output logic     vppEn,
  output logic     done
);

  typedef enum logic [3:0] {
    S_IDLE, S_SETUP, S_LATCH, S_PULSE, S_VSET, S_VWAIT,
    S_READ, S_CMP, S_RDCMD, S_FIN_OK, S_FIN_BAD
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  always_comb begin
    nextState = state;
    strb      = '0;
    strb.wrSel = WR_DATA;
    flashWe   = 1'b0;
    flashRe   = 1'b0;
    done      = 1'b0;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          strb.loadStart = 1'b1;
          nextState = S_SETUP;
        end
      end
      S_SETUP: begin
        flashWe     = 1'b1;
        strb.wrSel  = WR_PROG;
        strb.incCnt = 1'b1;
        nextState   = S_LATCH;
      end
      S_LATCH: begin
        flashWe        = 1'b1;
        strb.wrSel     = WR_DATA;
        strb.loadPulse = 1'b1;
        nextState      = S_PULSE;
      end
      S_PULSE: if (timerZero) nextState = S_VSET;
      S_VSET: begin
        flashWe         = 1'b1;
        strb.wrSel      = WR_VERIFY;
        strb.loadVerify = 1'b1;
        nextState       = S_VWAIT;
      end
      S_VWAIT: if (timerZero) nextState = S_READ;
      S_READ: begin
        flashRe   = 1'b1;
        nextState = S_CMP;
      end
      S_CMP: begin
        if (match) begin
          if (lastAddr) begin
            nextState = S_RDCMD;
          end else begin
            strb.incAddr = 1'b1;
            strb.clrCnt  = 1'b1;
            nextState    = S_SETUP;
          end
        end else if (cntMax) begin
          strb.setFail = 1'b1;
          nextState    = S_FIN_BAD;
        end else begin
          nextState = S_SETUP;
        end
      end
      S_RDCMD: begin
        flashWe      = 1'b1;
        strb.wrSel   = WR_READ;
        strb.setPass = 1'b1;
        nextState    = S_FIN_OK;
      end
      S_FIN_OK, S_FIN_BAD: begin
        done      = 1'b1;
        nextState = S_IDLE;
      end
      default: nextState = S_IDLE;
    endcase
  end

  assign vppEn = (state != S_IDLE) && (state != S_FIN_OK) && (state != S_FIN_BAD);

  // R3
  pulse_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_PULSE) && !timerZero |=> (state == S_PULSE) && !flashWe);

  // R11
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

// File: rtl/flash_prog_seq.sv
module flash_prog_seq
  import fps_pkg::*;
#(
  parameter int AW         = 8,
  parameter int PULSE_CYC  = 20,
  parameter int VERIFY_CYC = 12,
  parameter int MAX_PULSES = 25
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  logic                             start,
  input  logic [AW-1:0]                    startAddr,
  input  logic [AW-1:0]                    endAddr,
  output logic [AW-1:0]                    srcAddr,
  input  logic [7:0]                       srcData,
  output logic [AW-1:0]                    flashAddr,
  output logic [7:0]                       flashWrData,
  output logic                             flashWe,
  output logic                             flashRe,
  input  logic [7:0]                       flashRdData,
  output logic                             vppEn,
  output logic                             done,
  output logic                             pass,
  output logic [AW-1:0]                    failAddr,
  output logic [$clog2(MAX_PULSES+1)-1:0]  failCount
);

  localparam int CW   = $clog2(MAX_PULSES + 1);
  localparam int TMAX = (PULSE_CYC > VERIFY_CYC) ? PULSE_CYC : VERIFY_CYC;
  localparam int TW   = $clog2(TMAX + 1);

  strobes_t      strb;
  logic          timerZero, lastAddr, match, cntMax;
  logic [AW-1:0] curAddr;

  fps_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .start     (start),
    .timerZero (timerZero),
    .lastAddr  (lastAddr),
    .match     (match),
    .cntMax    (cntMax),
    .strb      (strb),
    .flashWe   (flashWe),
    .flashRe   (flashRe),
    .vppEn     (vppEn),
    .done      (done)
  );

  fps_dpath #(
    .AW(AW), .CW(CW), .TW(TW),
    .PULSE_CYC(PULSE_CYC), .VERIFY_CYC(VERIFY_CYC), .MAX_PULSES(MAX_PULSES)
  ) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .startAddr   (startAddr),
    .endAddr     (endAddr),
    .srcData     (srcData),
    .flashRdData (flashRdData),
    .curAddr     (curAddr),
    .wrData      (flashWrData),
    .timerZero   (timerZero),
    .lastAddr    (lastAddr),
    .match       (match),
    .cntMax      (cntMax),
    .passFlag    (pass),
    .failAddr    (failAddr),
    .failCount   (failCount)
  );

  assign srcAddr   = curAddr;
  assign flashAddr = curAddr;

  // R8
  rdcmd_before_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (done && pass) |-> $past(flashWe) && ($past(flashWrData) == CMD_READ));

  // R9
  vpp_on_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    flashWe |-> vppEn);

endmodule

// File: tb/sim_flash_prog_seq.sv
`timescale 1ns/1ps
module sim_flash_prog_seq;

  localparam int AW    = 8;
  localparam int PULSE = 20;
  localparam int VER   = 12;
  localparam int MAXP  = 25;
  localparam int CW    = $clog2(MAXP + 1);

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [AW-1:0] startAddr = '0, endAddr = '0;
  logic [AW-1:0] srcAddr, flashAddr, failAddr;
  logic [7:0]    srcData, flashWrData;
  logic [7:0]    flashRdData = 8'h00;
  logic          flashWe, flashRe, vppEn, done, pass;
  logic [CW-1:0] failCount;

  always #10 clk = ~clk;

  function automatic logic [7:0] expByte(input logic [AW-1:0] a);
    return 8'(a * 7 + 3);
  endfunction

  assign srcData = expByte(srcAddr);

  flash_prog_seq #(.AW(AW), .PULSE_CYC(PULSE), .VERIFY_CYC(VER), .MAX_PULSES(MAXP)) u0 (
    .clk(clk), .rstN(rstN), .start(start), .startAddr(startAddr), .endAddr(endAddr),
    .srcAddr(srcAddr), .srcData(srcData), .flashAddr(flashAddr), .flashWrData(flashWrData),
    .flashWe(flashWe), .flashRe(flashRe), .flashRdData(flashRdData), .vppEn(vppEn),
    .done(done), .pass(pass), .failAddr(failAddr), .failCount(failCount)
  );

  int total = 0, bad = 0;
  int need [256];
  int pulseCnt [256];
  int cyc = 0, dataCyc = 0, verCyc = 0, rcCyc = -10, lastDataAddr = -1;
  bit armed = 0, verArmed = 0;
  int seqErr, timeErr, orderErr, vppErr, doneCnt;
  int doneFailAddr, doneFailCnt;
  bit donePass, doneVpp, doneRc;

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // flash model and bus monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      if (flashWe) begin
        if (!vppEn) vppErr++;
        if (armed) begin
          armed = 0;
          if (flashWrData != expByte(flashAddr)) seqErr++;
          if (lastDataAddr >= 0 && int'(flashAddr) != lastDataAddr &&
              int'(flashAddr) != lastDataAddr + 1) orderErr++;
          lastDataAddr = int'(flashAddr);
          pulseCnt[flashAddr]++;
          dataCyc = cyc;
        end else if (flashWrData == 8'h40) begin
          armed = 1;
        end else if (flashWrData == 8'hC0) begin
          if (cyc - dataCyc != PULSE + 1) timeErr++;
          verCyc = cyc;
          verArmed = 1;
        end else if (flashWrData == 8'h00) begin
          rcCyc = cyc;
        end else begin
          seqErr++;
        end
      end
      if (flashRe) begin
        if (!verArmed || cyc - verCyc != VER + 1) timeErr++;
        verArmed = 0;
        flashRdData = (pulseCnt[flashAddr] >= need[flashAddr]) ?
                      expByte(flashAddr) : (expByte(flashAddr) ^ 8'h5A);
      end
      if (done) begin
        doneCnt++;
        donePass = pass;
        doneFailAddr = int'(failAddr);
        doneFailCnt = int'(failCount);
        doneVpp = vppEn;
        doneRc = (rcCyc == cyc - 1);
      end
      cyc++;
    end
  end

  task automatic setupNeeds();
    for (int i = 0; i < 256; i++) need[i] = 1;
  endtask

  task automatic runSeq(input int s, input int e, input bit poke);
    for (int i = 0; i < 256; i++) pulseCnt[i] = 0;
    seqErr = 0; timeErr = 0; orderErr = 0; vppErr = 0; doneCnt = 0;
    lastDataAddr = -1; armed = 0; verArmed = 0; rcCyc = -10;
    @(negedge clk);
    startAddr = AW'(s); endAddr = AW'(e); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    begin
      int w = 0;
      while (doneCnt == 0 && w < 20000) begin
        @(negedge clk);
        w++;
        if (poke && w == 50) begin
          start = 1'b1; startAddr = 8'd100; endAddr = 8'd100;
        end else if (poke && w == 51) begin
          start = 1'b0;
        end
      end
      if (w >= 20000) chk("watchdog run", 0, 1);
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic commonChecks();
    chk("R2 data write carries source byte", seqErr, 0);
    chk("R3/R4 pulse and settle spacing", timeErr, 0);
    chk("R9 vppEn on during writes", vppErr, 0);
    chk("R9 vppEn low at done", int'(doneVpp), 0);
    chk("R11 done one cycle", doneCnt, 1);
  endtask

  task automatic testReset();
    @(negedge clk);
    chk("R1 no write in reset", int'(flashWe), 0);
    chk("R1 no read in reset", int'(flashRe), 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 vppEn low idle", int'(vppEn), 0);
    chk("R1 done low idle", int'(done), 0);
    chk("R1 no write idle", int'(flashWe), 0);
  endtask

  task automatic testSingle();
    setupNeeds();
    runSeq(5, 5, 0);
    commonChecks();
    chk("R8 pass on single byte", int'(donePass), 1);
    chk("R8 read command before done", int'(doneRc), 1);
    chk("R2 one pulse at addr 5", pulseCnt[5], 1);
  endtask

  task automatic testRange();
    setupNeeds();
    need[10] = 1; need[11] = 3; need[12] = 2; need[13] = 1; need[14] = 4;
    runSeq(10, 14, 1);
    commonChecks();
    chk("R8 pass on range", int'(donePass), 1);
    chk("R8 read command before done", int'(doneRc), 1);
    chk("R5 pulses addr 10", pulseCnt[10], 1);
    chk("R5 pulses addr 11", pulseCnt[11], 3);
    chk("R5 pulses addr 12", pulseCnt[12], 2);
    chk("R5 pulses addr 13", pulseCnt[13], 1);
    chk("R5 pulses addr 14", pulseCnt[14], 4);
    chk("R7 ascending order", orderErr, 0);
    chk("R7 below range untouched", pulseCnt[9], 0);
    chk("R7 above range untouched", pulseCnt[15], 0);
    chk("R10 start while busy ignored", pulseCnt[100], 0);
  endtask

  task automatic testLimit();
    setupNeeds();
    need[40] = MAXP;
    runSeq(40, 40, 0);
    commonChecks();
    chk("R6 pass at exactly the cap", int'(donePass), 1);
    chk("R6 pulses at cap", pulseCnt[40], MAXP);
  endtask

  task automatic testFail();
    setupNeeds();
    need[31] = MAXP + 1;
    runSeq(30, 32, 0);
    commonChecks();
    chk("R6 fail flag", int'(donePass), 0);
    chk("R6 fail address", doneFailAddr, 31);
    chk("R6 fail count", doneFailCnt, MAXP);
    chk("R6 pulses on failing byte", pulseCnt[31], MAXP);
    chk("R6 later byte not pulsed", pulseCnt[32], 0);
    chk("R8 no read command on fail", int'(doneRc), 0);
  endtask

  initial begin
    #(150000 * 20);
    bad++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    setupNeeds();
    testReset();
    testSingle();
    testRange();
    testLimit();
    testFail();
    testSingle();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule